// File: doc/BRIEF.md
# Configurable Dual-Mode Distributed RAM

This block is a tiny memory of the kind found inside a logic cell. It holds two 16x1 arrays, F and G, and each array has its own 4-bit address. Reads are combinational. Each data output follows its current address with no clock involved. Writes are synchronous. Address, data and write enable are captured on one clock edge, and the write takes effect right after that edge. One configuration bit picks whether the rising or the falling clock edge is the active edge, and that choice applies to both arrays.

A second configuration bit selects the mode. In single-port mode the two arrays are separate memories. Each one has its own address, data and write enable, and both can be written in the same cycle. In dual-port mode the pair acts as one 16x1 RAM with two ports. The F port reads and writes, and a write through it stores the same data in both arrays at the F address. The G port only reads: its address picks the word shown on the G output and never causes a write.

Both configuration bits are static and may only change while reset is asserted. Reset does not clear the stored data. It only blocks writes until the internal reset release has passed through two active clock edges.

Top module: `cellram_dual`

## Requirements
- R1: `f_dout` always equals the F word at `f_addr`, and `g_dout` always equals the G word at `g_addr`. Both follow an address change with no clock edge.
- R2: With `cfg_fall_edge`=0, address, data and write enable are sampled on the rising edge of `clk`. Before that edge a read of the target address returns the old data, and after the edge it returns the new data.
- R3: With `cfg_fall_edge`=1, writes happen only on the falling edge of `clk`. A rising edge with the write enable high leaves the contents unchanged.
- R4: With `cfg_dual`=0, `f_we` writes `f_din` into F at `f_addr`, and `g_we` writes `g_din` into G at `g_addr`. The two writes are independent and may happen in the same cycle at different addresses.
- R5: With `cfg_dual`=1, a write with `f_we`=1 stores `f_din` in both F and G at `f_addr`.
- R6: With `cfg_dual`=1, `g_we` and `g_din` have no effect, and `g_addr` never selects a word to write.
- R7: With `cfg_dual`=1, `f_addr` and `g_addr` read different locations at the same time.
- R8: An active edge with the write enable of an array low leaves that array unchanged.
- R9: While `rst_n` is low, and on the first two active edges after it rises, no write takes place. Reset does not clear the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is chosen by `cfg_fall_edge` |
| rst_n | input | 1 | Asynchronous active-low reset that blocks writes |
| cfg_fall_edge | input | 1 | 0: rising-edge writes, 1: falling-edge writes |
| cfg_dual | input | 1 | 0: single-port mode, 1: dual-port mode |
| f_addr | input | 4 | F address (read; write address in both modes) |
| g_addr | input | 4 | G address (read; write address only in single-port mode) |
| f_din | input | 1 | F write data |
| g_din | input | 1 | G write data (single-port mode only) |
| f_we | input | 1 | F write enable |
| g_we | input | 1 | G write enable (single-port mode only) |
| f_dout | output | 1 | F word at `f_addr` |
| g_dout | output | 1 | G word at `g_addr` |

## Verification
The assertions assume that `cfg_dual` and `cfg_fall_edge` stay constant whenever reset is released. They also assume that inputs are stable around the selected active edge. Changing the polarity bit toggles the internal clock, and a mode change mid-run would break the relation between the two ports. For these reasons the bench changes both configuration bits only while `rst_n` is low, and it waits for the two-edge release before any write. It drives inputs one nanosecond after a rising edge, so they are settled before the next rising edge and before the falling edge in between. It checks results one nanosecond after the selected edge.

// File: rtl/cellram_pkg.sv
package cellram_pkg;

  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned WORD_W_DEF = 1;
  localparam int unsigned NUM_BANKS  = 2;

  typedef enum logic {
    BANK_F = 1'b0,
    BANK_G = 1'b1
  } bank_id_e;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_DUAL   = 1'b1
  } ram_mode_e;

endpackage

// File: rtl/cellram_edge_sel.sv
module cellram_edge_sel (
  input  logic clk,
  input  logic fall_edge,
  input  logic rst_n,
  output logic clk_act,
  output logic wr_ok
);

  logic [1:0] rel_q;
  logic [1:0] rel_d;

  // static polarity choice: inverting the clock moves the active edge
  assign clk_act = clk ^ fall_edge;

  always_comb begin
    rel_d = {rel_q[0], 1'b1};
  end

  always_ff @(posedge clk_act or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 2'b00;
    end else begin
      rel_q <= rel_d;
    end
  end

  assign wr_ok = rel_q[1];

endmodule

// File: rtl/cellram_wr_route.sv
module cellram_wr_route #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 1
) (
  input  logic              dual,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [WORD_W-1:0] f_din,
  input  logic [WORD_W-1:0] g_din,
  input  logic              f_we,
  input  logic              g_we,
  output logic [ADDR_W-1:0] f_waddr,
  output logic [ADDR_W-1:0] g_waddr,
  output logic [WORD_W-1:0] f_wdata,
  output logic [WORD_W-1:0] g_wdata,
  output logic              f_wen,
  output logic              g_wen
);

  always_comb begin
    f_waddr = f_addr;
    f_wdata = f_din;
    f_wen   = f_we & wr_ok;
    if (dual) begin
      // G array shadows the F port; G inputs are unused
      g_waddr = f_addr;
      g_wdata = f_din;
      g_wen   = f_we & wr_ok;
    end else begin
      g_waddr = g_addr;
      g_wdata = g_din;
      g_wen   = g_we & wr_ok;
    end
  end

endmodule

// File: rtl/cellram_bank.sv
module cellram_bank #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned WORD_W = 1
) (
  input  logic              clk_act,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned BITS  = DEPTH * WORD_W;

  logic [BITS-1:0] mem_q;
  logic [BITS-1:0] mem_d;

  function automatic logic [WORD_W-1:0] word_at(input logic [BITS-1:0] v,
                                                input logic [ADDR_W-1:0] a);
    return v[int'(a)*WORD_W +: WORD_W];
  endfunction

  always_comb begin
    mem_d = mem_q;
    if (wen) begin
      mem_d[int'(waddr)*WORD_W +: WORD_W] = wdata;
    end
  end

  // contents are deliberately not reset
  always_ff @(posedge clk_act) begin
    mem_q <= mem_d;
  end

  assign rdata = word_at(mem_q, raddr);

  // R2: written word present after the active edge
  p_word_written_r2: assert property (@(posedge clk_act) disable iff (!rst_n)
    wen |=> (word_at(mem_q, $past(waddr)) == $past(wdata)));

  // R8: no enable, no change anywhere in the array
  p_idle_hold_r8: assert property (@(posedge clk_act) disable iff (!rst_n)
    !wen |=> $stable(mem_q));

endmodule

// File: rtl/cellram_dual.sv
module cellram_dual #(
  parameter int unsigned ADDR_W = cellram_pkg::ADDR_W_DEF,
  parameter int unsigned WORD_W = cellram_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fall_edge,
  input  logic              cfg_dual,
  input  logic [ADDR_W-1:0] f_addr,
  input  logic [ADDR_W-1:0] g_addr,
  input  logic [WORD_W-1:0] f_din,
  input  logic [WORD_W-1:0] g_din,
  input  logic              f_we,
  input  logic              g_we,
  output logic [WORD_W-1:0] f_dout,
  output logic [WORD_W-1:0] g_dout
);
  import cellram_pkg::*;

  logic clk_act;
  logic wr_ok;

  logic [NUM_BANKS-1:0][ADDR_W-1:0] waddr;
  logic [NUM_BANKS-1:0][ADDR_W-1:0] raddr;
  logic [NUM_BANKS-1:0][WORD_W-1:0] wdata;
  logic [NUM_BANKS-1:0][WORD_W-1:0] rdata;
  logic [NUM_BANKS-1:0]             wen;

  ram_mode_e mode;
  assign mode = ram_mode_e'(cfg_dual);

  cellram_edge_sel u_edge (
    .clk       (clk),
    .fall_edge (cfg_fall_edge),
    .rst_n     (rst_n),
    .clk_act   (clk_act),
    .wr_ok     (wr_ok)
  );

  cellram_wr_route #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_route (
    .dual    (mode == MODE_DUAL),
    .wr_ok   (wr_ok),
    .f_addr  (f_addr),
    .g_addr  (g_addr),
    .f_din   (f_din),
    .g_din   (g_din),
    .f_we    (f_we),
    .g_we    (g_we),
    .f_waddr (waddr[BANK_F]),
    .g_waddr (waddr[BANK_G]),
    .f_wdata (wdata[BANK_F]),
    .g_wdata (wdata[BANK_G]),
    .f_wen   (wen[BANK_F]),
    .g_wen   (wen[BANK_G])
  );

  assign raddr[BANK_F] = f_addr;
  assign raddr[BANK_G] = g_addr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    cellram_bank #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bank (
      .clk_act (clk_act),
      .rst_n   (rst_n),
      .wen     (wen[b]),
      .waddr   (waddr[b]),
      .wdata   (wdata[b]),
      .raddr   (raddr[b]),
      .rdata   (rdata[b])
    );
  end

  assign f_dout = rdata[BANK_F];
  assign g_dout = rdata[BANK_G];

  // R5: an F write in dual mode shows up on the G port at the F address
  p_mirror_r5: assert property (@(posedge clk_act) disable iff (!rst_n)
    (cfg_dual && f_we && wr_ok) |=>
      ((g_addr != $past(f_addr)) || (g_dout == $past(f_din))));

  // R6: without an F write, the G word seen at a held address is unchanged
  p_g_port_silent_r6: assert property (@(posedge clk_act) disable iff (!rst_n)
    (cfg_dual && !(f_we && wr_ok)) |=>
      ((g_addr != $past(g_addr)) || (g_dout == $past(g_dout))));

  // R4: single-port G write lands at its own address
  p_single_g_r4: assert property (@(posedge clk_act) disable iff (!rst_n)
    (!cfg_dual && g_we && wr_ok) |=>
      ((g_addr != $past(g_addr)) || (g_dout == $past(g_din))));

  // R9: writes held off until the release has passed two active edges
  p_release_block_r9: assert property (@(posedge clk_act) disable iff (!rst_n)
    $rose(wr_ok) |-> $past(rst_n));

endmodule

// File: tb/cellram_dual_bench.sv
`timescale 1ns/100ps
module cellram_dual_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_fall_edge;
  logic       cfg_dual;
  logic [3:0] f_addr, g_addr;
  logic       f_din, g_din, f_we, g_we;
  logic       f_dout, g_dout;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic exp_f [16];
  logic exp_g [16];

  always #2 clk = ~clk;

  cellram_dual u_cellram_dual (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_dual      (cfg_dual),
    .f_addr        (f_addr),
    .g_addr        (g_addr),
    .f_din         (f_din),
    .g_din         (g_din),
    .f_we          (f_we),
    .g_we          (g_we),
    .f_dout        (f_dout),
    .g_dout        (g_dout)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic fall, input logic dual);
    @(posedge clk); #1;
    rst_n = 1'b0; f_we = 1'b0; g_we = 1'b0;
    cfg_fall_edge = fall; cfg_dual = dual;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  // one write cycle; model is updated from the requirements
  task automatic wr(input int fa, input logic fd, input logic fw,
                    input int ga, input logic gd, input logic gw);
    @(posedge clk); #1;
    f_addr = 4'(fa); f_din = fd; f_we = fw;
    g_addr = 4'(ga); g_din = gd; g_we = gw;
    if (cfg_fall_edge) @(negedge clk); else @(posedge clk);
    #1 f_we = 1'b0; g_we = 1'b0;
    if (fw) begin
      exp_f[fa] = fd;
      if (cfg_dual) exp_g[fa] = fd;
    end
    if (gw && !cfg_dual) exp_g[ga] = gd;
  endtask

  task automatic rd_check(input string tag, input int fa, input int ga);
    f_addr = 4'(fa); g_addr = 4'(ga);
    #0.5;
    check({tag, " f"}, f_dout, exp_f[fa]);
    check({tag, " g"}, g_dout, exp_g[ga]);
  endtask

  task automatic fill_single();
    for (int i = 0; i < 16; i++) wr(i, logic'(i % 2), 1'b1, i, logic'((i / 2) % 2), 1'b1);
  endtask

  task automatic t_async_read_r1();
    for (int i = 0; i < 16; i++) rd_check("R1 read", i, 15 - i);
  endtask

  task automatic t_rise_r2();
    @(posedge clk); #1;
    f_addr = 4'd5; f_din = ~exp_f[5]; f_we = 1'b1; g_we = 1'b0;
    #0.5 check("R2 before edge", f_dout, exp_f[5]);
    @(posedge clk); #1 f_we = 1'b0;
    exp_f[5] = f_din;
    check("R2 after edge", f_dout, exp_f[5]);
  endtask

  task automatic t_fall_r3();
    // enable high across a rising edge only
    @(negedge clk); #1;
    f_addr = 4'd9; f_din = ~exp_f[9]; f_we = 1'b1; g_we = 1'b0;
    @(posedge clk); #1 f_we = 1'b0;
    check("R3 rising edge ignored", f_dout, exp_f[9]);
    wr(9, ~exp_f[9], 1'b1, 0, 1'b0, 1'b0);
    rd_check("R3 falling write", 9, 0);
  endtask

  task automatic t_single_r4();
    wr(3, ~exp_f[3], 1'b1, 12, ~exp_g[12], 1'b1);
    rd_check("R4 both", 3, 12);
    rd_check("R4 other cells", 12, 3);
    wr(7, ~exp_f[7], 1'b1, 2, 1'b0, 1'b0);
    rd_check("R4 f only", 7, 7);
  endtask

  task automatic t_dual_r5();
    wr(6, ~exp_g[6], 1'b1, 1, 1'b0, 1'b0);
    rd_check("R5 mirror", 6, 6);
    wr(11, ~exp_f[11], 1'b1, 4, ~exp_f[11], 1'b1);
    rd_check("R5 mirror2", 11, 11);
  endtask

  task automatic t_dual_r6();
    logic old;
    old = exp_g[2];
    wr(8, exp_f[8], 1'b0, 2, ~old, 1'b1);
    rd_check("R6 g_we ignored", 8, 2);
    check("R6 g cell kept", g_dout, old);
  endtask

  task automatic t_dual_r7();
    wr(0, 1'b1, 1'b1, 0, 1'b0, 1'b0);
    wr(15, 1'b0, 1'b1, 0, 1'b0, 1'b0);
    rd_check("R7 split read", 0, 15);
    rd_check("R7 split read rev", 15, 0);
  endtask

  task automatic t_we_low_r8();
    wr(4, ~exp_f[4], 1'b0, 10, ~exp_g[10], 1'b0);
    rd_check("R8 no write", 4, 10);
  endtask

  task automatic t_reset_r9();
    @(posedge clk); #1;
    rst_n = 1'b0;
    f_addr = 4'd1; f_din = ~exp_f[1]; f_we = 1'b1;
    g_addr = 4'd14; g_din = ~exp_g[14]; g_we = 1'b1;
    repeat (2) @(posedge clk);
    #1 f_we = 1'b0; g_we = 1'b0;
    rd_check("R9 held in reset", 1, 14);
    // write attempt on the first edge after release
    @(posedge clk); #1;
    rst_n = 1'b1;
    f_addr = 4'd1; f_din = ~exp_f[1]; f_we = 1'b1;
    @(posedge clk); #1 f_we = 1'b0;
    rd_check("R9 first edge blocked", 1, 14);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_fall_edge = 1'b0; cfg_dual = 1'b0;
    f_addr = '0; g_addr = '0; f_din = 1'b0; g_din = 1'b0; f_we = 1'b0; g_we = 1'b0;
    apply_reset(1'b0, 1'b0);
    fill_single();
    t_async_read_r1();
    t_rise_r2();
    t_single_r4();
    t_we_low_r8();
    t_reset_r9();
    apply_reset(1'b1, 1'b0);
    t_fall_r3();
    t_single_r4();
    apply_reset(1'b0, 1'b1);
    t_dual_r5();
    t_dual_r6();
    t_dual_r7();
    t_we_low_r8();
    apply_reset(1'b1, 1'b1);
    t_dual_r5();
    t_dual_r6();
    t_async_read_r1();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule